// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Acceptance Unit

This block keeps the interrupt state of one processor: for every vector it records whether a request is waiting, whether the core is servicing it, and whether it came in level-triggered. Requests enter on an accept port. The block works out a processor priority from a programmable task priority and the class of the highest vector in service. It offers the core the highest waiting vector whose 16-vector class lies strictly above that priority.

The core takes an offered vector with an acknowledge strobe and retires the highest in-service vector with an end-of-interrupt strobe. When the retired vector was level-triggered, the block sends the vector out on a one-cycle broadcast so that the interrupt source can re-arm. The task priority can be loaded in full through a register port, or loaded and read by class through a 4-bit alias.

The priority result and the offered vector are combinational from the state registers. They are therefore valid in the cycle after any strobe takes effect.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset no vector is waiting, in service or level-marked, the task priority and processor priority are 0, irqAvail is 0 and eoiBcastValid is 0.
- R2: When irqAvail is 1, irqVector is the highest-numbered waiting vector. The search covers all NUM_VEC vectors, held as 32-bit words with vector v in word v>>5, bit v&31.
- R3: procPriority equals tprValue when tprValue[7:4] >= S[7:4]. Otherwise it equals {S[7:4],4'h0}. S is the highest in-service vector, or 0 when none is in service.
- R4: irqAvail is 1 only when a vector is waiting and {top[7:4],4'h0} > procPriority, the comparison being strictly greater. Waiting vectors 0..15 are never offered while procPriority is 0.
- R5: ackStrobe while irqAvail is 1 clears the waiting bit of irqVector and sets its in-service bit. ackStrobe while irqAvail is 0 changes no state.
- R6: eoiStrobe clears the in-service bit of the highest in-service vector. When nothing is in service, the strobe changes no state.
- R7: If the vector retired by eoiStrobe was level-marked, its mark is cleared and eoiBcastValid is 1 for exactly the next cycle, with eoiBcastVector equal to that vector. An edge-marked retirement gives no broadcast.
- R8: An accept (acceptLevel 1 = level, 0 = edge) for a vector that is already waiting is dropped when it is level. Any other accept sets the waiting bit and sets the vector's level mark to acceptLevel.
- R9: Accepts take effect only when hwEnable and swEnable are both 1.
- R10: tprWrite loads tprValue from tprWrData. crWrite loads tprValue with {crWrData,4'h0}. When both are asserted, the register port wins. crRdData always shows tprValue[7:4].
- R11: When ackStrobe and acceptValid act on the same vector in one cycle, the acknowledge is applied first. The vector ends up both in service and waiting, with its level mark taken from the accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwEnable | input | 1 | Hardware enable for accepts |
| swEnable | input | 1 | Software enable for accepts |
| acceptValid | input | 1 | Interrupt request strobe |
| acceptVector | input | VEC_W | Requested vector |
| acceptLevel | input | 1 | 1 = level-triggered request |
| ackStrobe | input | 1 | Core takes the offered vector |
| eoiStrobe | input | 1 | End of interrupt |
| tprWrite | input | 1 | Full task priority write |
| tprWrData | input | VEC_W | Task priority write value |
| crWrite | input | 1 | 4-bit class alias write |
| crWrData | input | 4 | Class alias write value |
| crRdData | output | 4 | Class alias read value |
| tprValue | output | VEC_W | Current task priority |
| procPriority | output | VEC_W | Current processor priority |
| irqAvail | output | 1 | A deliverable vector is offered |
| irqVector | output | VEC_W | Offered vector |
| eoiBcastValid | output | 1 | Level-triggered EOI broadcast pulse |
| eoiBcastVector | output | VEC_W | Vector carried by the broadcast |

## Verification
The bench runs a reference model of the three maps and the task priority next to the design. It compares the offered vector, the processor priority, the alias read and the broadcast after every operation. One sweep raises every vector from 16 to 255 in rising order, so each new request must take over the offered slot. It then drains the vectors by alternating acknowledge and end-of-interrupt, which separates a correct top-down search from one that picks the wrong word or bit. A task-priority sweep against a fixed waiting vector places the strictly-greater class boundary exactly. Dedicated sequences cover repeated level and edge requests, enable gating, same-cycle acknowledge-and-accept, and EOI with nothing in service; these separate the drop rule and the level mark from a plain set-on-request design.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef struct packed {
    logic ack;
    logic eoi;
    logic accept;
    logic level;
    logic tprLoad;
    logic aliasLoad;
  } ctrl_strobes_t;
endpackage

// File: rtl/irq_highest.sv
module irq_highest #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int WSEL_W    = $clog2(NUM_WORDS),
  localparam int BIT_W     = $clog2(WORD_W)
) (
  input  logic [NUM_VEC-1:0] vecMap,
  output logic               found,
  output logic [VEC_W-1:0]   topIdx
);
  logic [NUM_WORDS-1:0] wordAny;
  logic [WSEL_W-1:0]    topWord;
  logic [BIT_W-1:0]     topBit;
  logic [WORD_W-1:0]    selWord;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign wordAny[w] = |vecMap[w*WORD_W +: WORD_W];
  end

  always_comb begin
    topWord = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (wordAny[w]) topWord = WSEL_W'(w);
    selWord = vecMap[topWord*WORD_W +: WORD_W];
    topBit = '0;
    for (int b = 0; b < WORD_W; b++)
      if (selWord[b]) topBit = BIT_W'(b);
  end

  assign found  = |wordAny;
  assign topIdx = {topWord, topBit};
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_accept_pkg::*;
(
  input  logic          hwEnable,
  input  logic          swEnable,
  input  logic          acceptValid,
  input  logic          acceptLevel,
  input  logic          ackStrobe,
  input  logic          eoiStrobe,
  input  logic          tprWrite,
  input  logic          crWrite,
  input  logic          irqAvail,
  input  logic          isrFound,
  output ctrl_strobes_t strb
);
  always_comb begin
    strb.ack       = ackStrobe & irqAvail;
    strb.eoi       = eoiStrobe & isrFound;
    strb.accept    = acceptValid & hwEnable & swEnable;
    strb.level     = acceptLevel;
    strb.tprLoad   = tprWrite;
    strb.aliasLoad = crWrite & ~tprWrite;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_accept_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int CLS_LO = VEC_W - 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobes_t      strb,
  input  logic [VEC_W-1:0]   acceptVector,
  input  logic [VEC_W-1:0]   tprWrData,
  input  logic [3:0]         crWrData,
  output logic [VEC_W-1:0]   tprValue,
  output logic [VEC_W-1:0]   procPriority,
  output logic               irqAvail,
  output logic [VEC_W-1:0]   irqVector,
  output logic               isrFound,
  output logic               eoiBcastValid,
  output logic [VEC_W-1:0]   eoiBcastVector
);
  logic [NUM_VEC-1:0] pendMap, isrMap, tmrMap;
  logic [NUM_VEC-1:0] pendNext, isrNext, tmrNext;
  logic [VEC_W-1:0]   tprNext, isrTop, isrBase, bcVecNext;
  logic               pendFound, bcNext;

  irq_highest #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_pendSearch (
    .vecMap(pendMap), .found(pendFound), .topIdx(irqVector));
  irq_highest #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isrSearch (
    .vecMap(isrMap), .found(isrFound), .topIdx(isrTop));

  always_comb begin
    isrBase = isrFound ? isrTop : '0;
    if (tprValue[VEC_W-1:CLS_LO] >= isrBase[VEC_W-1:CLS_LO])
      procPriority = tprValue;
    else
      procPriority = {isrBase[VEC_W-1:CLS_LO], {CLS_LO{1'b0}}};
    irqAvail = pendFound &&
               ({irqVector[VEC_W-1:CLS_LO], {CLS_LO{1'b0}}} > procPriority);
  end

  always_comb begin
    pendNext  = pendMap;
    isrNext   = isrMap;
    tmrNext   = tmrMap;
    bcNext    = 1'b0;
    bcVecNext = '0;
    if (strb.ack) begin
      pendNext[irqVector] = 1'b0;
      isrNext[irqVector]  = 1'b1;
    end
    if (strb.eoi) begin
      isrNext[isrTop] = 1'b0;
      if (tmrMap[isrTop]) begin
        tmrNext[isrTop] = 1'b0;
        bcNext          = 1'b1;
        bcVecNext       = isrTop;
      end
    end
    if (strb.accept && !(pendNext[acceptVector] && strb.level)) begin
      pendNext[acceptVector] = 1'b1;
      tmrNext[acceptVector]  = strb.level;
    end
    if (strb.tprLoad)        tprNext = tprWrData;
    else if (strb.aliasLoad) tprNext = {crWrData, {CLS_LO{1'b0}}};
    else                     tprNext = tprValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMap        <= '0;
      isrMap         <= '0;
      tmrMap         <= '0;
      tprValue       <= '0;
      eoiBcastValid  <= 1'b0;
      eoiBcastVector <= '0;
    end else begin
      pendMap        <= pendNext;
      isrMap         <= isrNext;
      tmrMap         <= tmrNext;
      tprValue       <= tprNext;
      eoiBcastValid  <= bcNext;
      eoiBcastVector <= bcVecNext;
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwEnable,
  input  logic             swEnable,
  input  logic             acceptValid,
  input  logic [VEC_W-1:0] acceptVector,
  input  logic             acceptLevel,
  input  logic             ackStrobe,
  input  logic             eoiStrobe,
  input  logic             tprWrite,
  input  logic [VEC_W-1:0] tprWrData,
  input  logic             crWrite,
  input  logic [3:0]       crWrData,
  output logic [3:0]       crRdData,
  output logic [VEC_W-1:0] tprValue,
  output logic [VEC_W-1:0] procPriority,
  output logic             irqAvail,
  output logic [VEC_W-1:0] irqVector,
  output logic             eoiBcastValid,
  output logic [VEC_W-1:0] eoiBcastVector
);
  ctrl_strobes_t strb;
  logic          isrFound;

  irq_ctrl u_ctrl (
    .hwEnable(hwEnable), .swEnable(swEnable), .acceptValid(acceptValid),
    .acceptLevel(acceptLevel), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .tprWrite(tprWrite), .crWrite(crWrite), .irqAvail(irqAvail),
    .isrFound(isrFound), .strb(strb));

  irq_datapath #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .acceptVector(acceptVector),
    .tprWrData(tprWrData), .crWrData(crWrData), .tprValue(tprValue),
    .procPriority(procPriority), .irqAvail(irqAvail), .irqVector(irqVector),
    .isrFound(isrFound), .eoiBcastValid(eoiBcastValid),
    .eoiBcastVector(eoiBcastVector));

  assign crRdData = tprValue[VEC_W-1 -: 4];
endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             eoiStrobe,
  input logic             tprWrite,
  input logic             crWrite,
  input logic [3:0]       crWrData,
  input logic [VEC_W-1:0] tprValue,
  input logic [VEC_W-1:0] procPriority,
  input logic             irqAvail,
  input logic [VEC_W-1:0] irqVector,
  input logic             eoiBcastValid
);
  a_r3_ppr_not_below_tpr: assert property (@(posedge clk) disable iff (!rstN)
    procPriority >= tprValue);

  a_r4_offer_above_ppr: assert property (@(posedge clk) disable iff (!rstN)
    irqAvail |-> ({irqVector[VEC_W-1 -: 4], {(VEC_W-4){1'b0}}} > procPriority));

  a_r7_bcast_after_eoi: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcastValid |-> $past(eoiStrobe));

  a_r10_alias_load: assert property (@(posedge clk) disable iff (!rstN)
    (crWrite && !tprWrite) |=> (tprValue == {$past(crWrData), {(VEC_W-4){1'b0}}}));
endmodule

bind irq_accept_unit irq_accept_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .eoiStrobe(eoiStrobe), .tprWrite(tprWrite),
  .crWrite(crWrite), .crWrData(crWrData), .tprValue(tprValue),
  .procPriority(procPriority), .irqAvail(irqAvail), .irqVector(irqVector),
  .eoiBcastValid(eoiBcastValid));

// File: tb/irq_accept_unit_bench.sv
module irq_accept_unit_bench;
  logic clk = 0, rstN = 0;
  logic hwEnable = 1, swEnable = 1, acceptValid = 0, acceptLevel = 0;
  logic ackStrobe = 0, eoiStrobe = 0, tprWrite = 0, crWrite = 0;
  logic [7:0] acceptVector = 0, tprWrData = 0;
  logic [3:0] crWrData = 0;
  logic [3:0] crRdData;
  logic [7:0] tprValue, procPriority, irqVector, eoiBcastVector;
  logic irqAvail, eoiBcastValid;

  int checks = 0, errors = 0;
  logic [255:0] mPend = '0, mIsr = '0, mTmr = '0;
  logic [7:0] mTpr = 0;
  bit expBc = 0;
  int expBcVec = 0;

  always #2 clk = ~clk;

  irq_accept_unit u_irq_accept_unit (.*);

  function automatic int mTop(logic [255:0] m);
    for (int i = 255; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int mPpr();
    int s = mTop(mIsr);
    if (s < 0) s = 0;
    if ((mTpr >> 4) >= (s >> 4)) return mTpr;
    return s & 8'hF0;
  endfunction

  function automatic int mOffer();
    int p = mTop(mPend);
    if (p < 0) return -1;
    if ((p & 8'hF0) > mPpr()) return p;
    return -1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    int o = mOffer();
    check(req, "irqAvail", int'(irqAvail), (o >= 0) ? 1 : 0);
    if (o >= 0) check(req, "irqVector", int'(irqVector), o);
    check(req, "procPriority", int'(procPriority), mPpr());
    check(req, "tprValue", int'(tprValue), int'(mTpr));
    check(req, "crRdData", int'(crRdData), int'(mTpr[7:4]));
    check(req, "eoiBcastValid", int'(eoiBcastValid), int'(expBc));
    if (expBc) check(req, "eoiBcastVector", int'(eoiBcastVector), expBcVec);
  endtask

  task automatic op(bit acc, int vec, bit lvl, bit ack, bit eoi,
                    bit tw, int td, bit cw, int cd, string req);
    int offer, etop;
    @(negedge clk);
    acceptValid = acc; acceptVector = 8'(vec); acceptLevel = lvl;
    ackStrobe = ack; eoiStrobe = eoi; tprWrite = tw; tprWrData = 8'(td);
    crWrite = cw; crWrData = 4'(cd);
    offer = mOffer();
    etop = mTop(mIsr);
    expBc = 0;
    if (ack && offer >= 0) begin mPend[offer] = 0; mIsr[offer] = 1; end
    if (eoi && etop >= 0) begin
      mIsr[etop] = 0;
      if (mTmr[etop]) begin mTmr[etop] = 0; expBc = 1; expBcVec = etop; end
    end
    if (acc && hwEnable && swEnable && !(mPend[vec] && lvl)) begin
      mPend[vec] = 1; mTmr[vec] = lvl;
    end
    if (tw) mTpr = 8'(td);
    else if (cw) mTpr = {4'(cd), 4'h0};
    @(negedge clk);
    acceptValid = 0; ackStrobe = 0; eoiStrobe = 0; tprWrite = 0; crWrite = 0;
    checkAll(req);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1;
    @(negedge clk);
    checkAll("R1");

    // R9: enable gating
    hwEnable = 1; swEnable = 0;
    op(1, 8'hE5, 0, 0, 0, 0, 0, 0, 0, "R9");
    hwEnable = 0; swEnable = 1;
    op(1, 8'hE5, 1, 0, 0, 0, 0, 0, 0, "R9");
    hwEnable = 1; swEnable = 1;

    // R2: raise every vector 16..255 in rising order
    for (int v = 16; v < 256; v++) op(1, v, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R5/R6: drain top-down by ack then eoi
    for (int v = 16; v < 256; v++) begin
      op(0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
      op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
    end
    // R4: classes 0 never offered at ppr 0
    op(1, 8'h05, 0, 0, 0, 0, 0, 0, 0, "R4");
    op(1, 8'h0F, 1, 0, 0, 0, 0, 0, 0, "R4");
    // R5: ack with nothing offered changes nothing
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
    // R6: eoi with nothing in service
    op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");

    // R7: level retirement broadcasts
    op(1, 8'h61, 1, 0, 0, 0, 0, 0, 0, "R7");
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
    op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
    check("R7", "bcastVec61", int'(eoiBcastVector), 8'h61);
    // R8: level repeat on edge-waiting vector is dropped
    op(1, 8'h62, 0, 0, 0, 0, 0, 0, 0, "R8");
    op(1, 8'h62, 1, 0, 0, 0, 0, 0, 0, "R8");
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
    op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
    check("R8", "noBcastDropped", int'(eoiBcastValid), 0);
    // R8: edge repeat clears the level mark
    op(1, 8'h63, 1, 0, 0, 0, 0, 0, 0, "R8");
    op(1, 8'h63, 0, 0, 0, 0, 0, 0, 0, "R8");
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
    op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");

    // R4/R10: tpr sweep against waiting 0x80
    op(1, 8'h80, 0, 0, 0, 0, 0, 0, 0, "R4");
    for (int t = 0; t < 256; t += 3) op(0, 0, 0, 0, 0, 1, t, 0, 0, "R4");
    op(0, 0, 0, 0, 0, 1, 8'h7F, 0, 0, "R4");
    op(0, 0, 0, 0, 0, 1, 8'h80, 0, 0, "R4");
    // R10: alias write, both ports at once
    op(0, 0, 0, 0, 0, 0, 0, 1, 9, "R10");
    op(0, 0, 0, 0, 0, 1, 8'h27, 1, 4'hC, "R10");
    op(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10");

    // R3: in-service class against tpr
    op(0, 0, 0, 0, 0, 1, 8'h30, 0, 0, "R3");
    op(1, 8'hA0, 0, 0, 0, 0, 0, 0, 0, "R3");
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, "R3");
    check("R3", "pprIsA0", int'(procPriority), 8'hA0);
    op(0, 0, 0, 0, 0, 1, 8'hB5, 0, 0, "R3");
    op(1, 8'hB7, 0, 0, 0, 0, 0, 0, 0, "R3");
    op(1, 8'hC1, 0, 0, 0, 0, 0, 0, 0, "R3");
    op(0, 0, 0, 0, 0, 1, 8'h00, 0, 0, "R3");
    for (int i = 0; i < 6; i++) op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");

    // R11: ack and accept of the same vector together
    op(1, 8'hD0, 0, 0, 0, 0, 0, 0, 0, "R11");
    op(1, 8'hD0, 1, 1, 0, 0, 0, 0, 0, "R11");
    op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R11");
    check("R11", "bcastD0", int'(eoiBcastValid), 1);
    check("R11", "reofferD0", int'(irqVector), 8'hD0);
    summary();
  end
endmodule